// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-port synchronous static memory whose address, control and write data are all taken into registers on the rising clock edge. An access begins with a start strobe that loads the address. Later cycles with the advance input high step through the remaining beats of a four-word group. A burst counter produces the low two address bits in either linear or interleaved order, and the upper address bits stay fixed. Read data passes through an output register, so the word for an access captured at one edge becomes visible after the following edge.

Writes need no separate strobe. The write decision is captured with the address, and the array is updated one edge later. A global write stores every byte lane. Otherwise a byte-write qualifier together with per-lane selects chooses which lanes are stored. A sleep input blocks all new accesses and freezes the burst counter. An asynchronous output enable gates the read-valid flag and the data bus.

Top module: `bsram_top`

## Requirements
- R1: After reset no read data is valid, and the burst counter is unloaded: an advance with no earlier start performs no access.
- R2: A read started at clock edge E returns its word on `rdata_o` with `rvalid_o` high after edge E+1. The word is valid for exactly one cycle.
- R3: Each edge with `adv_i` high, `start_i` low and `sleep_i` low, after a start, accesses the next beat. Beats keep wrapping modulo 4 past the fourth beat, and the upper address bits stay those of the start address.
- R4: With the mode captured at start equal to 0, beat n uses low address bits (start offset + n) mod 4.
- R5: With the mode captured at start equal to 1, beat n uses low address bits (start offset XOR n).
- R6: With `gwr_i` high, an access writes all lanes from `wdata_i`, whatever `bwe_i` and `bsel_i` are, and returns no read data.
- R7: With `gwr_i` low and `bwe_i` high, lane i (bits [9i+8:9i] when lanes are 9 bits wide) is written only when `bsel_i[i]` is 1. If `bsel_i` is 0 the access changes nothing and returns no data. With both `gwr_i` and `bwe_i` low, the access is a read.
- R8: At an edge with `sleep_i` high, no access starts, advances or writes, and the burst counter and the stored address hold.
- R9: `rvalid_o` is the registered read-valid flag ANDed with `oe_i`, combinationally. `rdata_o` is zero whenever `rvalid_o` is low.
- R10: A start during a burst abandons that burst and reloads the counter from the new address and mode on the same edge.
- R11: A read issued on the edge after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start an access at `addr_i` |
| adv_i | input | 1 | Advance to the next burst beat |
| addr_i | input | ADDR_W | Start address |
| ilv_i | input | 1 | Burst order, captured at start: 0 linear, 1 interleaved |
| gwr_i | input | 1 | Global write, all lanes |
| bwe_i | input | 1 | Byte-write qualifier |
| bsel_i | input | LANES | Per-lane write selects |
| wdata_i | input | LANES*LANE_W | Write data |
| sleep_i | input | 1 | Block all new accesses |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid and driven |

## Verification
The bench builds the block with a 6-bit address (64 words), two lanes and 9-bit lanes. At this size it can first fill every word and then read back every four-word group from all four start offsets in both burst orders. Lane-select patterns, sleep during a start and during an advance, output-enable gating, wrapping past four beats, a restart in mid-burst, and write-then-read on adjacent edges each get directed cycles. All of them are compared against an arithmetic model kept in the bench.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef logic [1:0] beat_t;

    typedef struct packed {
        logic vld;
        logic wr;
    } op_ctl_t;

    // Low address bits of a burst beat for the selected order
    function automatic beat_t beat_low(input beat_t off, input beat_t n, input logic ilv);
        beat_t r;
        if (ilv) r = off ^ n;
        else     r = beat_t'(off + n);
        return r;
    endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic              sleep_i,
    input  logic              ilv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              acc_o,
    output logic [ADDR_W-1:0] acc_addr_o
);

    localparam int HI_W = ADDR_W - 2;

    logic            loaded_q;
    logic [HI_W-1:0] hi_q;
    beat_t           off_q;
    beat_t           cnt_q;
    logic            ilv_q;
    beat_t           cnt_nxt;

    assign cnt_nxt = beat_t'(cnt_q + 2'd1);

    always_comb begin
        acc_o      = !sleep_i && (start_i || (adv_i && loaded_q));
        acc_addr_o = start_i ? addr_i : {hi_q, beat_low(off_q, cnt_nxt, ilv_q)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded_q <= 1'b0;
            hi_q     <= '0;
            off_q    <= '0;
            cnt_q    <= '0;
            ilv_q    <= 1'b0;
        end else if (!sleep_i) begin
            if (start_i) begin
                loaded_q <= 1'b1;
                hi_q     <= addr_i[ADDR_W-1:2];
                off_q    <= addr_i[1:0];
                cnt_q    <= '0;
                ilv_q    <= ilv_i;
            end else if (adv_i && loaded_q) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R3: upper bits fixed while advancing
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !start_i && !sleep_i && loaded_q) |=> $stable(hi_q));

    // R3: counter steps by one per advance
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !start_i && !sleep_i && loaded_q) |=> (cnt_q == beat_t'($past(cnt_q) + 2'd1)));

    // R10: start reloads offset and clears beat count
    a_r10_start_reload: assert property (@(posedge clk) disable iff (rst)
        (start_i && !sleep_i) |=> (cnt_q == 2'd0 && off_q == $past(addr_i[1:0]) && loaded_q));

    // R8: sleep freezes the counter state
    a_r8_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(cnt_q) && $stable(off_q) && $stable(hi_q)));

endmodule

// File: rtl/bsram_in_reg.sv
module bsram_in_reg
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_i,
    input  logic [ADDR_W-1:0]       acc_addr_i,
    input  logic                    sleep_i,
    input  logic                    gwr_i,
    input  logic                    bwe_i,
    input  logic [LANES-1:0]        bsel_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output op_ctl_t                 op_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [LANES-1:0]        mask_o,
    output logic [LANES*LANE_W-1:0] data_o
);

    logic [LANES-1:0] mask_d;

    always_comb begin
        if (gwr_i)      mask_d = '1;
        else if (bwe_i) mask_d = bsel_i;
        else            mask_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_o   <= '0;
            addr_o <= '0;
            mask_o <= '0;
            data_o <= '0;
        end else begin
            op_o.vld <= acc_i;
            op_o.wr  <= gwr_i || bwe_i;
            addr_o   <= acc_addr_i;
            mask_o   <= mask_d;
            data_o   <= wdata_i;
        end
    end

    // R8: nothing captured while asleep
    a_r8_no_capture: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> !op_o.vld);

    // R6: global write stores all lanes
    a_r6_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (acc_i && gwr_i) |=> (op_o.wr && mask_o == '1));

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_ctl_t                 op_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [LANES*LANE_W-1:0] data_i,
    output logic                    rd_vld_o,
    output logic [LANES*LANE_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic do_rd;
    logic do_wr;

    assign do_rd = op_i.vld && !op_i.wr;
    assign do_wr = op_i.vld && op_i.wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_rd;

        always_ff @(posedge clk) begin
            if (do_wr && mask_i[g]) lane_mem[addr_i] <= data_i[g*LANE_W +: LANE_W];
            if (do_rd)              lane_rd <= lane_mem[addr_i];
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = lane_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld_o <= 1'b0;
        else     rd_vld_o <= do_rd;
    end

    // R2: a captured read yields data one edge later
    a_r2_read_flag: assert property (@(posedge clk) disable iff (rst)
        (op_i.vld && !op_i.wr) |=> rd_vld_o);

    // R7: writes return no read data
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_i.vld && op_i.wr) |=> !rd_vld_o);

endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    adv_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    ilv_i,
    input  logic                    gwr_i,
    input  logic                    bwe_i,
    input  logic [LANES-1:0]        bsel_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    sleep_i,
    input  logic                    oe_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic              acc;
    logic [ADDR_W-1:0] acc_addr;
    op_ctl_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] data_q;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_data;

    bsram_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .adv_i      (adv_i),
        .sleep_i    (sleep_i),
        .ilv_i      (ilv_i),
        .addr_i     (addr_i),
        .acc_o      (acc),
        .acc_addr_o (acc_addr)
    );

    bsram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) inreg_i (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .acc_addr_i (acc_addr),
        .sleep_i    (sleep_i),
        .gwr_i      (gwr_i),
        .bwe_i      (bwe_i),
        .bsel_i     (bsel_i),
        .wdata_i    (wdata_i),
        .op_o       (op_q),
        .addr_o     (addr_q),
        .mask_o     (mask_q),
        .data_o     (data_q)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_q),
        .addr_i    (addr_q),
        .mask_i    (mask_q),
        .data_i    (data_q),
        .rd_vld_o  (rd_vld),
        .rd_data_o (rd_data)
    );

    always_comb begin
        rvalid_o = rd_vld && oe_i;
        rdata_o  = rvalid_o ? rd_data : '0;
    end

    // R2: a read started at E is valid after E+1
    a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
        (start_i && !sleep_i && !gwr_i && !bwe_i) |-> ##2 rd_vld);

endmodule

// File: tb/bsram_top_tb_top.sv
module bsram_top_tb_top;

    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i, adv_i, ilv_i, gwr_i, bwe_i, sleep_i, oe_i;
    logic [AW-1:0] addr_i;
    logic [LN-1:0] bsel_i;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] mm [64];
    logic          m_loaded;
    logic [3:0]    m_hi;
    logic [1:0]    m_off, m_cnt;
    logic          m_ilv;
    logic          s1_acc, s1_wr;
    logic [AW-1:0] s1_a;
    logic [LN-1:0] s1_mask;
    logic [DW-1:0] s1_d;

    always #5 clk = ~clk;

    bsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .adv_i(adv_i), .addr_i(addr_i),
        .ilv_i(ilv_i), .gwr_i(gwr_i), .bwe_i(bwe_i), .bsel_i(bsel_i),
        .wdata_i(wdata_i), .sleep_i(sleep_i), .oe_i(oe_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [2:0] k);
        return {a, k, a ^ 6'h2a, ~k};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus (called at a negedge), then check at next negedge
    task automatic cyc(input logic st, input logic adv, input logic [AW-1:0] a, input logic ilv,
                       input logic gw, input logic bw, input logic [LN-1:0] bs,
                       input logic [DW-1:0] wd, input logic slp, input logic oe, input string tag);
        logic          c_acc, c_wr, exp_v;
        logic [AW-1:0] c_a;
        logic [LN-1:0] c_mask;
        logic [DW-1:0] exp_d;
        start_i = st; adv_i = adv; addr_i = a; ilv_i = ilv; gwr_i = gw; bwe_i = bw;
        bsel_i = bs; wdata_i = wd; sleep_i = slp; oe_i = oe;
        c_acc = 1'b0; c_a = '0;
        if (!slp) begin
            if (st) begin
                m_loaded = 1'b1; m_hi = a[5:2]; m_off = a[1:0]; m_cnt = 2'd0; m_ilv = ilv;
                c_acc = 1'b1; c_a = a;
            end else if (adv && m_loaded) begin
                m_cnt = m_cnt + 2'd1;
                c_acc = 1'b1;
                c_a = {m_hi, (m_ilv ? (m_off ^ m_cnt) : (m_off + m_cnt))};
            end
        end
        c_wr = gw | bw;
        c_mask = gw ? 2'b11 : (bw ? bs : 2'b00);
        @(negedge clk);
        exp_v = s1_acc && !s1_wr && oe;
        exp_d = exp_v ? mm[s1_a] : '0;
        if (s1_acc && s1_wr) begin
            for (int l = 0; l < LN; l++)
                if (s1_mask[l]) mm[s1_a][l*LW +: LW] = s1_d[l*LW +: LW];
        end
        chk(rvalid_o == exp_v, {tag, " valid"}, {17'd0, rvalid_o}, {17'd0, exp_v});
        chk(rdata_o === exp_d, {tag, " data"}, rdata_o, exp_d);
        s1_acc = c_acc; s1_wr = c_wr; s1_a = c_a; s1_mask = c_mask; s1_d = wd;
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 1, tag);
    endtask

    task automatic rd_start(input logic [AW-1:0] a, input logic ilv, input string tag);
        cyc(1, 0, a, ilv, 0, 0, '0, '0, 0, 1, tag);
    endtask

    task automatic rd_adv(input string tag);
        cyc(0, 1, '0, 0, 0, 0, '0, '0, 0, 1, tag);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        start_i = 0; adv_i = 0; addr_i = '0; ilv_i = 0; gwr_i = 0; bwe_i = 0;
        bsel_i = '0; wdata_i = '0; sleep_i = 0; oe_i = 1;
        m_loaded = 0; m_hi = '0; m_off = '0; m_cnt = '0; m_ilv = 0;
        s1_acc = 0; s1_wr = 0; s1_a = '0; s1_mask = '0; s1_d = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and advance without start
        idle("R1");
        cyc(0, 1, 6'd9, 0, 0, 0, '0, '0, 0, 1, "R1 adv-no-start");
        idle("R1");
        idle("R1");

        // R6: fill every word with global writes in linear bursts
        for (int g = 0; g < 16; g++) begin
            cyc(1, 0, 6'(g*4), 0, 1, 0, 2'b00, pat(6'(g*4), 3'd5), 0, 1, "R6 fill");
            for (int n = 1; n < 4; n++)
                cyc(0, 1, '0, 0, 1, 0, 2'b00, pat(6'(g*4+n), 3'd5), 0, 1, "R6 fill");
        end
        idle("R6");

        // R2, R3, R4, R5: every group, start offset and order
        for (int g = 0; g < 16; g++)
            for (int o = 0; o < 4; o++)
                for (int m = 0; m < 2; m++) begin
                    rd_start(6'(g*4+o), m[0], m ? "R2 R5 interleaved" : "R2 R4 linear");
                    for (int n = 1; n < 4; n++) rd_adv(m ? "R3 R5 interleaved" : "R3 R4 linear");
                end
        idle("R2");
        idle("R2");

        // R7: per-lane writes
        cyc(1, 0, 6'd5, 0, 0, 1, 2'b01, 18'h3ffff, 0, 1, "R7 lane0");
        idle("R7");
        rd_start(6'd5, 0, "R7 read");
        idle("R7"); idle("R7");
        cyc(1, 0, 6'd5, 0, 0, 1, 2'b10, 18'h00000, 0, 1, "R7 lane1");
        idle("R7");
        rd_start(6'd5, 0, "R7 read");
        idle("R7"); idle("R7");
        cyc(1, 0, 6'd5, 0, 0, 1, 2'b00, 18'h15555, 0, 1, "R7 no lanes");
        idle("R7");
        rd_start(6'd5, 0, "R7 read");
        idle("R7"); idle("R7");
        // R6: global write ignores deasserted selects
        cyc(1, 0, 6'd5, 0, 1, 0, 2'b00, 18'h2a5a5, 0, 1, "R6 global");
        idle("R6");
        rd_start(6'd5, 0, "R6 read");
        idle("R6"); idle("R6");

        // R11: write then immediate read of same word
        cyc(1, 0, 6'd9, 0, 1, 1, 2'b01, 18'h1c3c3, 0, 1, "R11 write");
        rd_start(6'd9, 0, "R11 read");
        idle("R11"); idle("R11");

        // R8: sleep blocks starts, advances and writes
        cyc(1, 0, 6'd12, 0, 0, 0, '0, '0, 1, 1, "R8 sleep start");
        idle("R8"); idle("R8");
        rd_start(6'd12, 0, "R8 read");
        cyc(0, 1, '0, 0, 0, 0, '0, '0, 1, 1, "R8 sleep adv");
        rd_adv("R8 resume");
        idle("R8"); idle("R8");
        cyc(1, 0, 6'd13, 0, 1, 0, '0, 18'h0f0f0, 1, 1, "R8 sleep write");
        idle("R8");
        rd_start(6'd13, 0, "R8 read");
        idle("R8"); idle("R8");

        // R9: output enable gates the read
        rd_start(6'd17, 0, "R9");
        cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 0, "R9 oe low");
        rd_start(6'd18, 0, "R9");
        idle("R9");
        cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 0, "R9 oe low");
        idle("R9");

        // R3: wrap past four beats, linear and interleaved
        rd_start(6'd26, 0, "R3 wrap");
        for (int n = 0; n < 6; n++) rd_adv("R3 wrap");
        rd_start(6'd41, 1, "R3 wrap");
        for (int n = 0; n < 6; n++) rd_adv("R3 wrap");
        idle("R3"); idle("R3");

        // R10: restart in mid-burst
        rd_start(6'd20, 0, "R10");
        rd_adv("R10");
        rd_start(6'd35, 1, "R10 restart");
        rd_adv("R10");
        rd_adv("R10");
        idle("R10"); idle("R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule